// File: doc/BRIEF.md
# Reset and Clock Startup Sequencer

This block decides when a microcontroller core leaves reset and which clock it runs from. A power-on reset puts it into a hold state. Once power-on is released, it qualifies the external oscillator by counting that oscillator's rising edges inside a fixed window. If the oscillator qualifies, the system runs from it. If it does not, the system falls back to an internal self clock, and the block retries the qualification at regular intervals until the oscillator passes.

An external reset pin is filtered, so that glitches shorter than a minimum low time do nothing. An accepted external reset holds the internal reset for a fixed stretch. If the oscillator was already qualified, no new qualification is run. A stop request gates the system clocks. An external wake interrupt runs a full qualification before the clocks come back.

A power-on flag records that a power-on reset occurred, and software clears it. The current sequencer state is brought out on a three-bit status port. All timing is counted in cycles of `clk`.

Top module: `rst_clk_seq`

## Requirements
- R1: While `por_n` is low, the outputs are: `state_o` = 0 (power-up hold), `sys_rst_n` = 0, `por_flag` = 1, `use_osc` = 0 and `clk_run` = 1.
- R2: One clock after `por_n` rises, `state_o` = 1 (qualifying) and `sys_rst_n` stays 0. The oscillator passes when P_EDGES synchronized rising edges of `osc_in` arrive within P_WINDOW cycles. After a pass, the reset stretch (`state_o` = 3) ends in `state_o` = 4 (run), with `use_osc` = 1 and `sys_rst_n` = 1.
- R3: If the window expires first, the stretch ends in `state_o` = 2 (self clock), with `use_osc` = 0 and `sys_rst_n` = 1.
- R4: Define the low time as the number of consecutive synchronized samples in which `ext_rst_n` is low. A low time shorter than P_RST_MIN (2) changes neither `state_o` nor `sys_rst_n`. A low time of P_RST_MIN or more drives `sys_rst_n` to 0 (`state_o` = 3).
- R5: After an accepted external reset with `use_osc` = 1, the block goes straight to run without entering `state_o` = 1. With `use_osc` = 0, it re-enters `state_o` = 1.
- R6: The internal reset stretch lasts between 192 and 196 cycles. For an external reset, this is counted from the release of `ext_rst_n` to the rise of `sys_rst_n`; otherwise it is the number of cycles spent in `state_o` = 3.
- R7: In run, a `stop_req` pulse enters `state_o` = 5 with `clk_run` = 0 and `use_osc` = 0. A `wake_irq` pulse enters `state_o` = 6, where `clk_run` stays 0 during qualification. A pass returns to run with `use_osc` = 1; a fail goes to self clock with `use_osc` = 0.
- R8: In self clock, a new qualification starts P_RETRY cycles after the previous one ends. The oscillator is not selected before then. A later pass sets `use_osc` = 1 and `state_o` = 4.
- R9: A `flag_clr` pulse clears `por_flag`. An external reset leaves it unchanged, and a power-on reset sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Power-on reset indication, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| osc_in | input | 1 | Oscillator activity, asynchronous |
| stop_req | input | 1 | Request to enter stop mode |
| wake_irq | input | 1 | External wake interrupt |
| flag_clr | input | 1 | Software write-one-to-clear of the power-on flag |
| sys_rst_n | output | 1 | Internal system reset, active low |
| clk_run | output | 1 | System clocks released |
| use_osc | output | 1 | 1 selects the oscillator, 0 selects the self clock |
| por_flag | output | 1 | Power-on reset occurred |
| state_o | output | 3 | Sequencer state code |

## Verification
The qualification is swept over oscillator half-periods from stuck (0) up to 6 cycles. Each half-period is classed arithmetically as a sure pass or a sure fail, and half-periods that fall in between are skipped. This separates a running oscillator from a stuck one and from one that toggles but too slowly. Reset pulses of one and of two samples tell the filter threshold apart. External resets issued from run and from self clock show whether qualification is skipped or repeated. Two stop/wake rounds are run: one with a live oscillator and one with a stuck oscillator, which separates the pass branch from the fallback branch.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    S_PWRUP    = 3'd0,
    S_QUAL     = 3'd1,
    S_SELFCLK  = 3'd2,
    S_RSTHOLD  = 3'd3,
    S_RUN      = 3'd4,
    S_STOP     = 3'd5,
    S_WAKEQUAL = 3'd6
  } seq_st_e;

  // width of a counter that must reach n-1
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 3) ? 1 : $clog2(n);
  endfunction

  // system reset is held in these states
  function automatic logic in_reset(input seq_st_e s);
    return (s == S_PWRUP) || (s == S_QUAL) || (s == S_RSTHOLD);
  endfunction

  // system clocks are gated in these states
  function automatic logic clocks_gated(input seq_st_e s);
    return (s == S_STOP) || (s == S_WAKEQUAL);
  endfunction
endpackage

// File: rtl/rst_filter.sv
module rst_filter #(
  parameter int MIN_LOW = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  output logic accepted
);
  localparam int W = $clog2(MIN_LOW + 1);

  logic         pin_m, pin_s;
  logic [W-1:0] low_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pin_m   <= 1'b1;
      pin_s   <= 1'b1;
      low_cnt <= '0;
    end else begin
      pin_m <= pin_n;
      pin_s <= pin_m;
      if (pin_s)
        low_cnt <= '0;
      else if (low_cnt != W'(MIN_LOW))
        low_cnt <= low_cnt + W'(1);
    end
  end

  assign accepted = (low_cnt == W'(MIN_LOW));

  // R4: acceptance needs at least two consecutive low samples
  a_r4_two_lows: assert property (@(posedge clk) disable iff (!por_n)
    $rose(accepted) |-> (!$past(pin_s, 1) && !$past(pin_s, 2)));
endmodule

// File: rtl/osc_qual.sv
module osc_qual #(
  parameter int EDGES  = 256,
  parameter int WINDOW = 4096
) (
  input  logic clk,
  input  logic por_n,
  input  logic osc_in,
  input  logic start,
  input  logic kill,
  output logic pass,
  output logic fail,
  output logic busy
);
  import seq_pkg::*;
  localparam int WW = cnt_w(WINDOW);
  localparam int EW = cnt_w(EDGES);

  logic          o_m, o_s, o_d;
  logic          rise;
  logic          active;
  logic [WW-1:0] win_cnt;
  logic [EW-1:0] edge_cnt;

  assign rise = o_s & ~o_d;
  assign pass = active && rise && (edge_cnt == EW'(EDGES - 1));
  assign fail = active && !pass && (win_cnt == WW'(WINDOW - 1));
  assign busy = active;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      o_m      <= 1'b0;
      o_s      <= 1'b0;
      o_d      <= 1'b0;
      active   <= 1'b0;
      win_cnt  <= '0;
      edge_cnt <= '0;
    end else begin
      o_m <= osc_in;
      o_s <= o_m;
      o_d <= o_s;
      if (start) begin
        active   <= 1'b1;
        win_cnt  <= '0;
        edge_cnt <= '0;
      end else if (kill || pass || fail) begin
        active <= 1'b0;
      end else if (active) begin
        win_cnt <= win_cnt + WW'(1);
        if (rise) edge_cnt <= edge_cnt + EW'(1);
      end
    end
  end

  // R2: a qualification only begins on a start request
  a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!por_n)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm #(
  parameter int STRETCH = 192,
  parameter int RETRY   = 1024
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_acc,
  input  logic              chk_pass,
  input  logic              chk_fail,
  input  logic              chk_busy,
  input  logic              stop_req,
  input  logic              wake_irq,
  input  logic              flag_clr,
  output seq_pkg::seq_st_e  st,
  output logic              osc_ok,
  output logic              start_chk,
  output logic              kill_chk,
  output logic              por_flag
);
  import seq_pkg::*;
  localparam int SW = cnt_w(STRETCH);
  localparam int RW = cnt_w(RETRY);

  seq_st_e       nxt;
  logic          ext_pend;
  logic          retry_fire;
  logic [SW-1:0] scnt;
  logic [RW-1:0] rcnt;

  always_comb begin
    nxt        = st;
    retry_fire = 1'b0;
    if (rst_acc && st != S_PWRUP) begin
      nxt = S_RSTHOLD;
    end else begin
      case (st)
        S_PWRUP:   nxt = S_QUAL;
        S_QUAL:    if (chk_pass || chk_fail) nxt = S_RSTHOLD;
        S_RSTHOLD: begin
          if (ext_pend && !osc_ok) nxt = S_QUAL;
          else if (!ext_pend && scnt == SW'(STRETCH - 1))
            nxt = osc_ok ? S_RUN : S_SELFCLK;
        end
        S_SELFCLK: begin
          if (stop_req) nxt = S_STOP;
          else if (chk_pass) nxt = S_RUN;
          else if (!chk_busy && rcnt == RW'(RETRY - 1)) retry_fire = 1'b1;
        end
        S_RUN:      if (stop_req) nxt = S_STOP;
        S_STOP:     if (wake_irq) nxt = S_WAKEQUAL;
        S_WAKEQUAL: begin
          if (chk_pass) nxt = S_RUN;
          else if (chk_fail) nxt = S_SELFCLK;
        end
        default:    nxt = S_PWRUP;
      endcase
    end
  end

  assign start_chk = retry_fire
                   || (nxt == S_QUAL && st != S_QUAL)
                   || (nxt == S_WAKEQUAL && st != S_WAKEQUAL);
  assign kill_chk  = rst_acc || (nxt == S_STOP);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st       <= S_PWRUP;
      osc_ok   <= 1'b0;
      ext_pend <= 1'b0;
      scnt     <= '0;
      rcnt     <= '0;
      por_flag <= 1'b1;
    end else begin
      st <= nxt;
      if (nxt == S_STOP)  osc_ok <= 1'b0;
      else if (chk_pass)  osc_ok <= 1'b1;
      else if (chk_fail)  osc_ok <= 1'b0;
      if (rst_acc) ext_pend <= 1'b1;
      else if (st == S_RSTHOLD) ext_pend <= 1'b0;
      if (st != S_RSTHOLD || rst_acc) scnt <= '0;
      else scnt <= scnt + SW'(1);
      if (st != S_SELFCLK || chk_busy || retry_fire) rcnt <= '0;
      else rcnt <= rcnt + RW'(1);
      if (flag_clr) por_flag <= 1'b0;
    end
  end

  // R1: the power-up hold state is only seen with the power-on flag set
  a_r1_pwrup_flag: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_PWRUP) |-> por_flag);
  // R5: a qualified oscillator skips requalification after external reset
  a_r5_skip_check: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_RSTHOLD && osc_ok && !rst_acc) |=> (st != S_QUAL));
  // R6: the stretch leaves only after the full count
  a_r6_stretch_len: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_RSTHOLD && $past(st) == S_RSTHOLD && !rst_acc && !ext_pend
     && (nxt == S_RUN || nxt == S_SELFCLK)) |-> (scnt == SW'(STRETCH - 1)));
  // R9: the flag only falls on a software clear
  a_r9_flag_sw_only: assert property (@(posedge clk) disable iff (!por_n)
    $fell(por_flag) |-> $past(flag_clr));
endmodule

// File: rtl/rst_clk_seq.sv
module rst_clk_seq #(
  parameter int P_EDGES   = 256,
  parameter int P_WINDOW  = 4096,
  parameter int P_STRETCH = 192,
  parameter int P_RETRY   = 1024,
  parameter int P_RST_MIN = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       ext_rst_n,
  input  logic       osc_in,
  input  logic       stop_req,
  input  logic       wake_irq,
  input  logic       flag_clr,
  output logic       sys_rst_n,
  output logic       clk_run,
  output logic       use_osc,
  output logic       por_flag,
  output logic [2:0] state_o
);
  import seq_pkg::*;

  logic    rst_acc;
  logic    chk_pass, chk_fail, chk_busy;
  logic    start_chk, kill_chk;
  logic    osc_ok;
  seq_st_e st;

  rst_filter #(.MIN_LOW(P_RST_MIN)) u_filt (
    .clk(clk), .por_n(por_n), .pin_n(ext_rst_n), .accepted(rst_acc)
  );

  osc_qual #(.EDGES(P_EDGES), .WINDOW(P_WINDOW)) u_qual (
    .clk(clk), .por_n(por_n), .osc_in(osc_in), .start(start_chk),
    .kill(kill_chk), .pass(chk_pass), .fail(chk_fail), .busy(chk_busy)
  );

  seq_fsm #(.STRETCH(P_STRETCH), .RETRY(P_RETRY)) u_fsm (
    .clk(clk), .por_n(por_n), .rst_acc(rst_acc), .chk_pass(chk_pass),
    .chk_fail(chk_fail), .chk_busy(chk_busy), .stop_req(stop_req),
    .wake_irq(wake_irq), .flag_clr(flag_clr), .st(st), .osc_ok(osc_ok),
    .start_chk(start_chk), .kill_chk(kill_chk), .por_flag(por_flag)
  );

  assign sys_rst_n = !in_reset(st);
  assign clk_run   = !clocks_gated(st);
  assign use_osc   = osc_ok;
  assign state_o   = st;

  // R7: clocks return on the oscillator only after a passing qualification
  a_r7_wake_gated: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(clk_run) && use_osc) |-> $past(chk_pass));
  // R3: the self clock state never selects the oscillator
  a_r3_selfclk_src: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(st == S_SELFCLK)) |-> !use_osc);
endmodule

// File: tb/rst_clk_seq_tb.sv
module rst_clk_seq_tb;
  localparam int CLK_P   = 10;
  localparam int EDGES   = 8;
  localparam int WINDOW  = 64;
  localparam int STRETCH = 192;
  localparam int RETRY   = 100;

  logic clk = 1'b0;
  logic por_n = 1'b0, ext_rst_n = 1'b1, osc_in = 1'b0;
  logic stop_req = 1'b0, wake_irq = 1'b0, flag_clr = 1'b0;
  logic sys_rst_n, clk_run, use_osc, por_flag;
  logic [2:0] state_o;

  int checks = 0, errors = 0;
  int osc_half = 0, ocnt = 0;

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    if (osc_half == 0) ocnt <= 0;
    else if (ocnt >= osc_half - 1) begin osc_in <= ~osc_in; ocnt <= 0; end
    else ocnt <= ocnt + 1;
  end

  rst_clk_seq #(.P_EDGES(EDGES), .P_WINDOW(WINDOW), .P_STRETCH(STRETCH),
                .P_RETRY(RETRY), .P_RST_MIN(2)) u_dut (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .osc_in(osc_in),
    .stop_req(stop_req), .wake_irq(wake_irq), .flag_clr(flag_clr),
    .sys_rst_n(sys_rst_n), .clk_run(clk_run), .use_osc(use_osc),
    .por_flag(por_flag), .state_o(state_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_por(input int h);
    por_n = 1'b0;
    osc_half = h;
    step(3);
    por_n = 1'b1;
  endtask

  task automatic wait_rel(input int lim);
    int n = 0;
    while (sys_rst_n !== 1'b1 && n < lim) begin step(1); n++; end
  endtask

  // 1 = sure pass, 0 = sure fail, -1 = too close to call
  function automatic int classify(input int h);
    if (h == 0) return 0;
    if (2 * h * (EDGES + 1) + 4 <= WINDOW) return 1;
    if (2 * h * (EDGES - 1) > WINDOW) return 0;
    return -1;
  endfunction

  task automatic ext_pulse(input int len);
    ext_rst_n = 1'b0;
    step(len);
    ext_rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired before the end of the run");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    step(2);
    chk("R1 state", state_o, 0);
    chk("R1 sys_rst_n", sys_rst_n, 0);
    chk("R1 por_flag", por_flag, 1);
    chk("R1 use_osc", use_osc, 0);
    chk("R1 clk_run", clk_run, 1);

    // R2 / R3 / R6 sweep over oscillator half-periods
    for (int h = 0; h <= 6; h++) begin
      int e;
      int n;
      e = classify(h);
      if (e < 0) continue;
      do_por(h);
      step(1);
      chk("R2 qualifying after power-on", state_o, 1);
      chk("R2 reset held while qualifying", sys_rst_n, 0);
      n = 0;
      while (state_o == 3'd1 && n < 300) begin step(1); n++; end
      n = 0;
      while (state_o == 3'd3 && n < 400) begin step(1); n++; end
      chk_rng("R6 stretch after qualification", n, 192, 196);
      chk(e ? "R2 run state" : "R3 self clock state", state_o, e ? 4 : 2);
      chk(e ? "R2 oscillator selected" : "R3 self clock selected", use_osc, e);
      chk("R2 R3 reset released", sys_rst_n, 1);
    end

    // R9 flag clear, survives external reset
    do_por(2);
    wait_rel(600);
    chk("R9 flag after power-on", por_flag, 1);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    chk("R9 flag cleared", por_flag, 0);

    // R4 short pulse ignored
    ext_pulse(1);
    step(8);
    chk("R4 short pulse state", state_o, 4);
    chk("R4 short pulse reset", sys_rst_n, 1);

    // R4 two-sample pulse accepted
    ext_pulse(2);
    step(3);
    chk("R4 two-sample pulse reset", sys_rst_n, 0);
    chk("R4 two-sample pulse state", state_o, 3);
    wait_rel(400);

    // R5 / R6 long external reset with oscillator running
    begin
      int n = 0;
      int seen = 0;
      ext_pulse(10);
      while (sys_rst_n !== 1'b1 && n < 400) begin
        step(1); n++;
        if (state_o == 3'd1) seen = 1;
      end
      chk_rng("R6 stretch after external reset", n, 192, 196);
      chk("R5 no requalification", seen, 0);
      chk("R5 back to run", state_o, 4);
      chk("R9 flag kept across external reset", por_flag, 0);
    end

    // R7 stop and wake with a live oscillator
    stop_req = 1'b1; step(1); stop_req = 1'b0;
    chk("R7 stop state", state_o, 5);
    chk("R7 clocks gated", clk_run, 0);
    chk("R7 oscillator deselected", use_osc, 0);
    step(20);
    chk("R7 stays stopped", state_o, 5);
    wake_irq = 1'b1; step(1); wake_irq = 1'b0;
    chk("R7 wake qualifying", state_o, 6);
    chk("R7 clocks still gated", clk_run, 0);
    begin
      int n = 0;
      while (clk_run !== 1'b1 && n < 200) begin step(1); n++; end
    end
    chk("R7 wake pass run", state_o, 4);
    chk("R7 wake pass oscillator", use_osc, 1);

    // R7 stop and wake with a stuck oscillator
    stop_req = 1'b1; step(1); stop_req = 1'b0;
    osc_half = 0;
    step(4);
    wake_irq = 1'b1; step(1); wake_irq = 1'b0;
    begin
      int n = 0;
      while (clk_run !== 1'b1 && n < 200) begin step(1); n++; end
    end
    chk("R7 wake fail self clock", state_o, 2);
    chk("R7 wake fail source", use_osc, 0);

    // R5 external reset without a qualified oscillator requalifies
    begin
      int n = 0;
      int seen = 0;
      ext_pulse(10);
      while (n < 12) begin
        step(1); n++;
        if (state_o == 3'd1) seen = 1;
      end
      chk("R5 requalification entered", seen, 1);
    end
    wait_rel(600);
    chk("R3 self clock after failed requalification", state_o, 2);

    // R8 periodic retry in self clock
    osc_half = 2;
    step(90);
    chk("R8 no switch before retry", use_osc, 0);
    begin
      int n = 0;
      while (use_osc !== 1'b1 && n < 400) begin step(1); n++; end
    end
    chk("R8 retry selects oscillator", use_osc, 1);
    chk("R8 retry run state", state_o, 4);

    // R9 power-on sets the flag again
    do_por(2);
    step(1);
    chk("R9 flag set by power-on", por_flag, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule